// File: doc/BRIEF.md
# Same-Line Load Batch Selector

This block keeps a circular queue of pending memory operations and, every cycle, picks a group of loads that can be served by a single cache access. Each slot holds an operation kind, a cache-line address, a tag and a ready flag. The oldest live slot (the head) decides what happens. When it is a ready load, the block looks from the head toward the tail for more ready loads that hit the same line, and it stops at the first ordering barrier. Each chosen load gets a distinct execution port. A ready store, fence or atomic at the head is sent out alone.

Port numbers come from a logarithmic-depth prefix network that first finds where the barrier cuts the queue and then ranks the surviving candidates. A multiplexer per port moves the chosen slot's index, line and tag onto that port's registered outputs. Issued slots are not compacted away. They are flagged dead and stay in place until the head moves past them, and the head skips every dead slot at the front of the queue in the same cycle.

Upstream logic enqueues operations, which may arrive ready or not yet ready. It sets the ready flag of a waiting slot later through a wake input that names the slot index.

Top module: `same_line_load_batcher`

## Requirements
- R1: An operation offered while `enq_ready` is high is written at the tail slot (head index plus occupancy, modulo the depth). `enq_kind` encodes 0 as load, 1 as store, 2 as fence and 3 as atomic. `enq_ready` is low when all DEPTH slots are occupied, and issued slots that the head has not yet passed still count as occupied.
- R2: After reset the queue is empty, no port is valid and `enq_ready` is high.
- R3: When the head slot is a live ready load, it is issued on port 0 with its own slot index, line and tag.
- R4: The other live ready loads whose line equals the head's line are issued on ports 1, 2, … in queue order from the head. Loads that are not ready, or that target another line, are skipped and do not take a port.
- R5: The scan stops at the first live fence, live atomic, or live store to the head's line. No slot beyond that point is issued in that cycle. A store to a different line does not stop the scan.
- R6: At most PORTS slots issue per cycle, and valid ports are always a contiguous group starting at port 0. Qualifying loads beyond the port count issue in a later cycle.
- R7: If the head slot is not ready, no port is valid in the following cycle.
- R8: A ready store, fence or atomic at the head is issued alone on port 0.
- R9: An issued slot is never issued again. The head advances past all dead slots at the front of the queue in the issuing cycle, which frees them for new operations, and port indices in one cycle are distinct.
- R10: Port outputs are registered. A selection made from the queue state in one cycle appears on the ports after the next rising clock edge and lasts one cycle.
- R11: A `wake_valid` pulse sets the ready flag of the slot at `wake_idx`, which lets that slot issue from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Offer an operation for enqueue |
| enq_kind | input | 2 | Operation kind: 0 load, 1 store, 2 fence, 3 atomic |
| enq_line | input | LINE_W | Cache-line address of the operation |
| enq_tag | input | TAG_W | Caller's tag, returned on issue |
| enq_rdy | input | 1 | Operation is ready on arrival |
| enq_ready | output | 1 | Queue has a free slot |
| wake_valid | input | 1 | Set the ready flag of one slot |
| wake_idx | input | IDX_W | Slot to be made ready |
| port_valid | output | PORTS | Per-port issue valid |
| port_idx | output | PORTS*IDX_W | Per-port slot index, port p at bits p*IDX_W |
| port_line | output | PORTS*LINE_W | Per-port line address |
| port_tag | output | PORTS*TAG_W | Per-port tag |

## Verification
The assertions hold on every cycle for the structural rules: valid ports are packed from port 0, port 0 carries the previous head, all valid ports share one line, and their indices are distinct. They also check that a non-load head issues alone, that an idle head produces no issue, and that occupancy never exceeds the depth. The bench scenarios are needed for the rest. Only they can show that the right loads are chosen, which covers skipping loads that are not ready or go to another line, cutting at fences, atomics and same-line stores while letting other-line stores pass, and spilling loads past the port limit into the next cycle. They also cover head retirement over dead slots in the middle of the queue and reuse of a freed slot once the tail has wrapped.

// File: rtl/lsq_batch_pkg.sv
package lsq_batch_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_FENCE  = 2'd2,
    OP_ATOMIC = 2'd3
  } op_kind_e;

endpackage

// File: rtl/lsq_prefix_net.sv
// Two Kogge-Stone style scans over the rotated queue (position 0 = head).
// First: exclusive OR of barrier flags -> where the scan is cut.
// Second: exclusive saturating count of surviving candidates -> port rank.
module lsq_prefix_net #(
  parameter int N  = 16,
  parameter int CW = 3
) (
  input  logic [N-1:0]  cand,
  input  logic [N-1:0]  blk,
  output logic [N-1:0]  pick,
  output logic [CW-1:0] rank [N]
);
  localparam int L = $clog2(N);
  localparam logic [CW:0] MAXV = (CW+1)'((1 << CW) - 1);

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s > MAXV) s = MAXV;
    return s[CW-1:0];
  endfunction

  logic          orv [L+1][N];
  logic [CW-1:0] cnt [L+1][N];

  for (genvar i = 0; i < N; i++) begin : g_seed_or
    assign orv[0][i] = blk[i];
  end

  for (genvar lv = 0; lv < L; lv++) begin : g_or_lvl
    for (genvar i = 0; i < N; i++) begin : g_or_node
      if (i >= (1 << lv)) begin : g_comb
        assign orv[lv+1][i] = orv[lv][i] | orv[lv][i-(1<<lv)];
      end else begin : g_pass
        assign orv[lv+1][i] = orv[lv][i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign pick[i] = cand[i];
    end else begin : g_rest
      assign pick[i] = cand[i] & ~orv[L][i-1];
    end
    assign cnt[0][i] = {{(CW-1){1'b0}}, pick[i]};
  end

  for (genvar lv = 0; lv < L; lv++) begin : g_cnt_lvl
    for (genvar i = 0; i < N; i++) begin : g_cnt_node
      if (i >= (1 << lv)) begin : g_comb
        assign cnt[lv+1][i] = sat_add(cnt[lv][i], cnt[lv][i-(1<<lv)]);
      end else begin : g_pass
        assign cnt[lv+1][i] = cnt[lv][i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_rank
    if (i == 0) begin : g_first
      assign rank[i] = '0;
    end else begin : g_rest
      assign rank[i] = cnt[L][i-1];
    end
  end

endmodule

// File: rtl/lsq_port_mux.sv
// One OR-multiplexer per execution port; each selected slot matches one port.
module lsq_port_mux #(
  parameter int N     = 16,
  parameter int PORTS = 4,
  parameter int RW    = 3,
  parameter int W     = 8
) (
  input  logic [N-1:0]   sel,
  input  logic [RW-1:0]  rank [N],
  input  logic [W-1:0]   din  [N],
  output logic [PORTS-1:0] vout,
  output logic [W-1:0]   dout [PORTS]
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic         hit;
    logic [W-1:0] acc;
    always_comb begin
      hit = 1'b0;
      acc = '0;
      for (int i = 0; i < N; i++) begin
        if (sel[i] && rank[i] == RW'(p)) begin
          hit = 1'b1;
          acc = acc | din[i];
        end
      end
    end
    assign vout[p] = hit;
    assign dout[p] = acc;
  end
endmodule

// File: rtl/same_line_load_batcher.sv
module same_line_load_batcher
  import lsq_batch_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PORTS  = 4,
  parameter int LINE_W = 32,
  parameter int TAG_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enq_valid,
  input  logic [1:0]               enq_kind,
  input  logic [LINE_W-1:0]        enq_line,
  input  logic [TAG_W-1:0]         enq_tag,
  input  logic                     enq_rdy,
  output logic                     enq_ready,
  input  logic                     wake_valid,
  input  logic [IDX_W-1:0]         wake_idx,
  output logic [PORTS-1:0]         port_valid,
  output logic [PORTS*IDX_W-1:0]   port_idx,
  output logic [PORTS*LINE_W-1:0]  port_line,
  output logic [PORTS*TAG_W-1:0]   port_tag
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int RANK_W = $clog2(PORTS + 1);
  localparam int PAY_W  = IDX_W + LINE_W + TAG_W;

  // Slot index reached by stepping 'off' places from 'base' around the ring.
  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] base,
                                                input logic [CNT_W-1:0] off);
    logic [CNT_W:0] s;
    s = (CNT_W+1)'(base) + (CNT_W+1)'(off);
    if (s >= (CNT_W+1)'(DEPTH)) s = s - (CNT_W+1)'(DEPTH);
    return s[IDX_W-1:0];
  endfunction

  // Slot storage
  logic              live_q [DEPTH];
  logic              rdy_q  [DEPTH];
  op_kind_e          kind_q [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [IDX_W-1:0]  head_q;
  logic [CNT_W-1:0]  count_q;

  // Rotated view: position 0 is the head
  logic [IDX_W-1:0]  phys_r [DEPTH];
  logic              occ_r  [DEPTH];
  logic              live_r [DEPTH];
  logic              rdy_r  [DEPTH];
  op_kind_e          kind_r [DEPTH];
  logic [LINE_W-1:0] line_r [DEPTH];
  logic [TAG_W-1:0]  tag_r  [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      phys_r[i] = wrap_add(head_q, CNT_W'(i));
      occ_r[i]  = CNT_W'(i) < count_q;
      live_r[i] = occ_r[i] && live_q[phys_r[i]];
      rdy_r[i]  = rdy_q[phys_r[i]];
      kind_r[i] = kind_q[phys_r[i]];
      line_r[i] = line_q[phys_r[i]];
      tag_r[i]  = tag_q[phys_r[i]];
    end
  end

  // Named head events (also watched by the checker)
  logic head_go;
  logic batch_go;
  logic solo_go;
  assign head_go  = live_r[0] && rdy_r[0];
  assign batch_go = head_go && (kind_r[0] == OP_LOAD);
  assign solo_go  = head_go && (kind_r[0] != OP_LOAD);

  // Candidate and barrier flags in rotated order
  logic [DEPTH-1:0] cand;
  logic [DEPTH-1:0] blk;
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cand[i] = batch_go && live_r[i] && rdy_r[i] &&
                (kind_r[i] == OP_LOAD) && (line_r[i] == line_r[0]);
      blk[i]  = live_r[i] && ((kind_r[i] == OP_FENCE) || (kind_r[i] == OP_ATOMIC) ||
                ((kind_r[i] == OP_STORE) && (line_r[i] == line_r[0])));
    end
  end

  logic [DEPTH-1:0]  pick;
  logic [RANK_W-1:0] rank [DEPTH];

  lsq_prefix_net #(.N(DEPTH), .CW(RANK_W)) u_prefix (
    .cand (cand),
    .blk  (blk),
    .pick (pick),
    .rank (rank)
  );

  logic [DEPTH-1:0] sel;
  logic [PAY_W-1:0] din [DEPTH];
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      sel[i] = (pick[i] && (rank[i] < RANK_W'(PORTS))) || ((i == 0) && solo_go);
      din[i] = {phys_r[i], line_r[i], tag_r[i]};
    end
  end

  logic [PORTS-1:0] mux_v;
  logic [PAY_W-1:0] mux_d [PORTS];

  lsq_port_mux #(.N(DEPTH), .PORTS(PORTS), .RW(RANK_W), .W(PAY_W)) u_mux (
    .sel  (sel),
    .rank (rank),
    .din  (din),
    .vout (mux_v),
    .dout (mux_d)
  );

  // Head retirement: count dead slots at the front after this cycle's issue
  logic [CNT_W-1:0] lead_cnt;
  always_comb begin
    logic stop;
    stop     = 1'b0;
    lead_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!stop) begin
        if (occ_r[i] && !(live_r[i] && !sel[i])) lead_cnt = lead_cnt + CNT_W'(1);
        else stop = 1'b1;
      end
    end
  end

  logic             enq_fire;
  logic [IDX_W-1:0] tail_idx;
  logic [IDX_W-1:0] head_nx;
  logic [CNT_W-1:0] count_nx;

  assign enq_ready = (count_q != CNT_W'(DEPTH));
  assign enq_fire  = enq_valid && enq_ready;
  assign tail_idx  = wrap_add(head_q, count_q);
  assign head_nx   = wrap_add(head_q, lead_cnt);
  assign count_nx  = count_q - lead_cnt + CNT_W'(enq_fire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        live_q[i] <= 1'b0;
        rdy_q[i]  <= 1'b0;
        kind_q[i] <= OP_LOAD;
        line_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sel[i]) live_q[phys_r[i]] <= 1'b0;
      end
      if (wake_valid) rdy_q[wake_idx] <= 1'b1;
      if (enq_fire) begin
        live_q[tail_idx] <= 1'b1;
        rdy_q[tail_idx]  <= enq_rdy;
        kind_q[tail_idx] <= op_kind_e'(enq_kind);
        line_q[tail_idx] <= enq_line;
        tag_q[tail_idx]  <= enq_tag;
      end
      head_q  <= head_nx;
      count_q <= count_nx;
    end
  end

  // Registered port outputs
  logic [PORTS-1:0]  pv_q;
  logic [IDX_W-1:0]  pidx_q  [PORTS];
  logic [LINE_W-1:0] pline_q [PORTS];
  logic [TAG_W-1:0]  ptag_q  [PORTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q <= '0;
      for (int p = 0; p < PORTS; p++) begin
        pidx_q[p]  <= '0;
        pline_q[p] <= '0;
        ptag_q[p]  <= '0;
      end
    end else begin
      pv_q <= mux_v;
      for (int p = 0; p < PORTS; p++) begin
        {pidx_q[p], pline_q[p], ptag_q[p]} <= mux_d[p];
      end
    end
  end

  assign port_valid = pv_q;
  for (genvar p = 0; p < PORTS; p++) begin : g_flat
    assign port_idx[p*IDX_W +: IDX_W]    = pidx_q[p];
    assign port_line[p*LINE_W +: LINE_W] = pline_q[p];
    assign port_tag[p*TAG_W +: TAG_W]    = ptag_q[p];
  end

endmodule

// File: rtl/batcher_chk.sv
module batcher_chk #(
  parameter int DEPTH  = 16,
  parameter int PORTS  = 4,
  parameter int IDX_W  = 4,
  parameter int LINE_W = 32,
  parameter int CNT_W  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [PORTS-1:0]        port_valid,
  input logic [PORTS*IDX_W-1:0]  port_idx,
  input logic [PORTS*LINE_W-1:0] port_line,
  input logic [IDX_W-1:0]        head_q,
  input logic [CNT_W-1:0]        count_q,
  input logic                    batch_go,
  input logic                    solo_go
);
  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R3
  head_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_valid) |-> (port_idx[IDX_W-1:0] == $past(head_q)));

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(batch_go || solo_go) |=> (port_valid == '0));

  // R8
  solo_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    solo_go |=> (port_valid == PORTS'(1)));

  for (genvar p = 1; p < PORTS; p++) begin : g_port_rules
    // R6
    port_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[p] |-> port_valid[p-1]);
    // R4
    same_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[p] |-> (port_line[p*LINE_W +: LINE_W] == port_line[LINE_W-1:0]));
    for (genvar q = 0; q < p; q++) begin : g_pair
      // R9
      distinct_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid[p] && port_valid[q]) |->
        (port_idx[p*IDX_W +: IDX_W] != port_idx[q*IDX_W +: IDX_W]));
    end
  end
endmodule

bind same_line_load_batcher batcher_chk #(
  .DEPTH(DEPTH), .PORTS(PORTS), .IDX_W(IDX_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_valid (port_valid),
  .port_idx   (port_idx),
  .port_line  (port_line),
  .head_q     (head_q),
  .count_q    (count_q),
  .batch_go   (batch_go),
  .solo_go    (solo_go)
);

// File: tb/same_line_load_batcher_tb.sv
module same_line_load_batcher_tb;
  localparam int DEPTH  = 16;
  localparam int PORTS  = 4;
  localparam int LINE_W = 32;
  localparam int TAG_W  = 8;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst_n = 1'b0;
  logic                    enq_valid = 1'b0;
  logic [1:0]              enq_kind = '0;
  logic [LINE_W-1:0]       enq_line = '0;
  logic [TAG_W-1:0]        enq_tag = '0;
  logic                    enq_rdy = 1'b0;
  logic                    enq_ready;
  logic                    wake_valid = 1'b0;
  logic [IDX_W-1:0]        wake_idx = '0;
  logic [PORTS-1:0]        port_valid;
  logic [PORTS*IDX_W-1:0]  port_idx;
  logic [PORTS*LINE_W-1:0] port_line;
  logic [PORTS*TAG_W-1:0]  port_tag;

  same_line_load_batcher #(.DEPTH(DEPTH), .PORTS(PORTS), .LINE_W(LINE_W), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_kind(enq_kind),
    .enq_line(enq_line), .enq_tag(enq_tag), .enq_rdy(enq_rdy), .enq_ready(enq_ready),
    .wake_valid(wake_valid), .wake_idx(wake_idx), .port_valid(port_valid),
    .port_idx(port_idx), .port_line(port_line), .port_tag(port_tag)
  );

  int checks = 0;
  int errors = 0;

  // Op byte: [7] ready, [6:5] kind (0 load,1 store,2 fence,3 atomic), [3:0] line.
  // ops byte k = op enqueued k-th (slot k after reset); op 0 always enters not ready.
  typedef struct packed {
    logic [63:0] ops;
    logic [3:0]  n;
    logic        wake;
    logic [3:0]  exp_valid;
    logic [15:0] exp_idx;   // nibble p = expected slot index on port p
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R4: skip not-ready (slot 3) and other-line (slot 2) loads
    '{ops:64'h0000_008A_0A8B_8A8A, n:4'd5, wake:1'b1, exp_valid:4'b0111, exp_idx:16'h0410},
    // R5: fence at slot 2 cuts the scan
    '{ops:64'h0000_0000_8A40_8A8A, n:4'd4, wake:1'b1, exp_valid:4'b0011, exp_idx:16'h0010},
    // R5: store to head line cuts the scan
    '{ops:64'h0000_0000_008A_2A8A, n:4'd3, wake:1'b1, exp_valid:4'b0001, exp_idx:16'h0000},
    // R5: store to another line does not cut
    '{ops:64'h0000_0000_008A_2B8A, n:4'd3, wake:1'b1, exp_valid:4'b0011, exp_idx:16'h0020},
    // R6: six same-line loads, first four issue
    '{ops:64'h0000_8A8A_8A8A_8A8A, n:4'd6, wake:1'b1, exp_valid:4'b1111, exp_idx:16'h3210},
    // R5: atomic at slot 2 cuts the scan
    '{ops:64'h0000_0000_8A60_8A8A, n:4'd4, wake:1'b1, exp_valid:4'b0011, exp_idx:16'h0010},
    // R8: atomic at head issues alone
    '{ops:64'h0000_0000_0000_8A60, n:4'd2, wake:1'b1, exp_valid:4'b0001, exp_idx:16'h0000},
    // R7: head never woken, nothing issues
    '{ops:64'h0000_0000_008A_8A0A, n:4'd3, wake:1'b0, exp_valid:4'b0000, exp_idx:16'h0000},
    // R8: fence at head issues alone
    '{ops:64'h0000_0000_0000_8A40, n:4'd2, wake:1'b1, exp_valid:4'b0001, exp_idx:16'h0000},
    // R8: store at head issues alone
    '{ops:64'h0000_0000_0000_8A2A, n:4'd2, wake:1'b1, exp_valid:4'b0001, exp_idx:16'h0000}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    enq_valid = 1'b0;
    wake_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic enq(input logic [1:0] k, input logic [3:0] l, input logic [7:0] t, input logic r);
    @(negedge clk);
    enq_valid = 1'b1;
    enq_kind  = k;
    enq_line  = {28'd0, l};
    enq_tag   = t;
    enq_rdy   = r;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic wake(input logic [3:0] i);
    @(negedge clk);
    wake_valid = 1'b1;
    wake_idx   = i;
    @(negedge clk);
    wake_valid = 1'b0;
  endtask

  function automatic logic [3:0] pidx(input int p);
    return port_idx[p*IDX_W +: IDX_W];
  endfunction

  task automatic chk_ports(input string req, input logic [3:0] ev, input logic [15:0] ei);
    chk(req, "port_valid", 32'(port_valid), 32'(ev));
    for (int p = 0; p < PORTS; p++) begin
      if (ev[p]) chk(req, $sformatf("port%0d idx", p), 32'(pidx(p)), 32'(ei[p*4 +: 4]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R2
    chk("R2", "port_valid after reset", 32'(port_valid), 32'd0);
    chk("R2", "enq_ready after reset", 32'(enq_ready), 32'd1);

    // Table walk: first issue cycle of each scenario (R3 port 0, R11 wake)
    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int k = 0; k < int'(VECS[v].n); k++) begin
        logic [7:0] op;
        op = VECS[v].ops[k*8 +: 8];
        enq(op[6:5], op[3:0], 8'(k), (k == 0) ? 1'b0 : op[7]);
      end
      if (VECS[v].wake) begin
        wake(4'd0);       // R11
        @(negedge clk);
      end else begin
        repeat (2) @(negedge clk);
      end
      chk_ports($sformatf("R3/vec%0d", v), VECS[v].exp_valid, VECS[v].exp_idx);
      for (int p = 0; p < PORTS; p++) begin
        if (VECS[v].exp_valid[p]) begin
          logic [3:0] s;
          s = VECS[v].exp_idx[p*4 +: 4];
          chk($sformatf("R4/vec%0d", v), $sformatf("port%0d line", p),
              port_line[p*LINE_W +: LINE_W], {28'd0, VECS[v].ops[s*8 +: 4]});
          chk($sformatf("R3/vec%0d", v), $sformatf("port%0d tag", p),
              32'(port_tag[p*TAG_W +: TAG_W]), 32'(s));
        end
      end
    end

    // R6 overflow spills into the next cycle; R10 one-cycle pulse
    do_reset();
    enq(2'd0, 4'hA, 8'd0, 1'b0);
    for (int k = 1; k < 6; k++) enq(2'd0, 4'hA, 8'(k), 1'b1);
    wake(4'd0);
    @(negedge clk);
    chk_ports("R6 first batch", 4'b1111, 16'h3210);
    @(negedge clk);
    chk_ports("R6 spill batch", 4'b0011, 16'h0054);
    @(negedge clk);
    chk_ports("R10 no repeat", 4'b0000, 16'h0000);

    // R9 dead slots mid-queue, head moves past them
    do_reset();
    enq(2'd0, 4'hA, 8'd0, 1'b0);
    enq(2'd0, 4'hA, 8'd1, 1'b1);
    enq(2'd0, 4'hB, 8'd2, 1'b1);
    enq(2'd0, 4'hA, 8'd3, 1'b0);
    enq(2'd0, 4'hA, 8'd4, 1'b1);
    wake(4'd0);
    @(negedge clk);
    chk_ports("R4 batch", 4'b0111, 16'h0410);
    @(negedge clk);
    chk_ports("R9 next head", 4'b0001, 16'h0002);
    chk("R9", "port0 line", port_line[LINE_W-1:0], 32'hB);
    @(negedge clk);
    chk_ports("R7 head not ready", 4'b0000, 16'h0000);
    wake(4'd3);
    @(negedge clk);
    chk_ports("R9 no reissue of slot 4", 4'b0001, 16'h0003);
    @(negedge clk);
    chk_ports("R9 queue drained", 4'b0000, 16'h0000);

    // R1 full queue, R9 slot reuse after wrap
    do_reset();
    for (int k = 0; k < DEPTH; k++) enq(2'd0, 4'h5, 8'(k), 1'b0);
    chk("R1", "enq_ready when full", 32'(enq_ready), 32'd0);
    wake(4'd0);
    @(negedge clk);
    chk_ports("R1 issue from full", 4'b0001, 16'h0000);
    chk("R9", "enq_ready after retire", 32'(enq_ready), 32'd1);
    enq(2'd0, 4'h5, 8'd16, 1'b1);
    chk("R1", "enq_ready full again", 32'(enq_ready), 32'd0);
    wake(4'd1);
    @(negedge clk);
    chk_ports("R9 wrapped slot joins batch", 4'b0011, 16'h0001);
    chk("R1", "port1 tag of wrapped slot", 32'(port_tag[TAG_W +: TAG_W]), 32'd16);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule